// File: doc/BRIEF.md
# Pipelined integer square root

The block takes an unsigned integer and returns its integer square root and the remainder that the root leaves. The remainder is the input minus the square of the root. It uses the restoring digit-by-digit method. The input is split into bit pairs, starting at the most significant pair. Each pair has its own stage. A stage brings the next pair into the running remainder, tries to subtract the root-so-far with `01` appended, and keeps either the difference or the unchanged trial value. It then shifts the new root bit in.

Two parameters set the block: the input width and the latency in clock cycles. When the latency is zero, the result is purely combinational and the clock, enable and clear inputs have no effect. When the latency is no larger than the stage count, that many register banks are spread evenly across the stages. Any latency beyond the stage count becomes extra register banks at the output. All registers share one active-high clock enable and one active-high asynchronous clear. The root and the remainder always travel together, so both outputs belong to the same input sample.

Top module: `isqrt_pipe`

## Requirements
- R1: For an input of W bits, the root output is ceil(W/2) bits wide and the remainder output is one bit wider. With W=9 this gives 5 and 6 bits, with W=6 it gives 3 and 4, and with W=4 it gives 2 and 3.
- R2: The root is the largest integer r with r*r <= x, so that (r+1)*(r+1) > x, for every input value x.
- R3: The remainder equals x - r*r and never exceeds 2*r.
- R4: With LATENCY > 0, a sample presented at an enabled rising clock edge appears on both outputs after exactly LATENCY enabled edges. Root and remainder come from the same sample.
- R5: With LATENCY = 0, the outputs follow the input combinationally, with no clock edge involved.
- R6: While the enable input is low, no register changes: the outputs hold their values and input changes have no effect. When the enable returns high, the samples already in flight continue and none is lost or repeated.
- R7: A high level on the clear input forces every register to zero at once, without a clock edge, so both outputs read zero. This is also the state after reset.
- R8: An input of zero gives root 0 and remainder 0. The all-ones input gives the largest root. For W=9 that input is 511, which gives root 22 and remainder 27.
- R9: When LATENCY is larger than the stage count, the surplus delay is added at the output and the total latency still equals LATENCY. For example, W=4 with LATENCY=4 uses two stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pipeline registers |
| ena | input | 1 | Active-high clock enable; all registers hold while it is low |
| aclr | input | 1 | Active-high asynchronous clear of all registers |
| radical | input | DATA_W | Unsigned input value |
| root | output | (DATA_W+1)/2 | Integer square root |
| remainder | output | (DATA_W+1)/2+1 | Input minus the square of the root |

## Verification
A corrupted stage register, or a wrong choice in a trial subtraction, appears at the ports as a root/remainder pair that breaks root*root + remainder = input, or that lets the remainder exceed twice the root. This shows up on the very sample that passed through the fault, exactly LATENCY enabled edges after that sample entered. A fault in enable gating appears as output movement during a held cycle, or as the following results coming out one slot early or late. A missing clear appears as non-zero outputs directly after the clear rises, before any clock edge. Every input value of each tested width is swept, so every pair pattern at every stage is driven through the pipeline.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

  // Number of register banks placed between stages (the rest go to the output).
  function automatic int inner_regs(input int n_stages, input int latency);
    return (latency < n_stages) ? latency : n_stages;
  endfunction

  // Stage k (1-based) is followed by a register when the evenly spread
  // bank count steps up at k.
  function automatic bit reg_after(input int k, input int n_stages, input int n_regs);
    if (n_regs <= 0) return 1'b0;
    return ((k * n_regs) / n_stages) != (((k - 1) * n_regs) / n_stages);
  endfunction

endpackage

// File: rtl/isqrt_stage.sv
module isqrt_stage #(
  parameter int ROOT_W = 5,
  parameter int STAGE  = 0,
  localparam int REM_W    = ROOT_W + 1,
  localparam int PAD_W    = 2 * ROOT_W,
  localparam int PAY_W    = PAD_W + ROOT_W + REM_W,
  localparam int TRY_W    = REM_W + 2,
  localparam int PAIR_LSB = PAD_W - 2 - 2 * STAGE
) (
  input  logic [PAY_W-1:0] pay_in,
  output logic [PAY_W-1:0] pay_out
);

  logic [PAD_W-1:0]  rad;
  logic [ROOT_W-1:0] root_in;
  logic [REM_W-1:0]  rem_in;
  logic [1:0]        pair;
  logic [TRY_W-1:0]  trial;
  logic [TRY_W-1:0]  subtr;
  logic [TRY_W-1:0]  diff;
  logic              fits;
  logic [ROOT_W-1:0] root_out;
  logic [REM_W-1:0]  rem_out;

  assign rad     = pay_in[PAY_W-1 -: PAD_W];
  assign root_in = pay_in[REM_W +: ROOT_W];
  assign rem_in  = pay_in[REM_W-1:0];

  // shift: bring the next bit pair into the running remainder
  assign pair  = rad[PAIR_LSB +: 2];
  assign trial = {rem_in, pair};
  // trial subtrahend: root so far with 01 appended
  assign subtr = TRY_W'({root_in, 2'b01});
  assign diff  = trial - subtr;
  assign fits  = (trial >= subtr);

  // select: keep the difference or restore the trial value
  always_comb begin
    if (fits) begin
      rem_out  = REM_W'(diff);
      root_out = ROOT_W'({root_in, 1'b1});
    end else begin
      rem_out  = REM_W'(trial);
      root_out = ROOT_W'({root_in, 1'b0});
    end
  end

  assign pay_out = {rad, root_out, rem_out};

endmodule

// File: rtl/isqrt_pipe_reg.sv
module isqrt_pipe_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             ena,
  input  logic             aclr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)     q <= '0;
    else if (ena) q <= d;
  end

  // R6: a disabled edge leaves the bank unchanged
  a_r6_hold_when_disabled: assert property (@(posedge clk) disable iff (aclr)
    !ena |=> $stable(q));

endmodule

// File: rtl/isqrt_pipe.sv
module isqrt_pipe #(
  parameter int DATA_W  = 9,
  parameter int LATENCY = 2,
  localparam int ROOT_W = (DATA_W + 1) / 2,
  localparam int REM_W  = ROOT_W + 1
) (
  input  logic              clk,
  input  logic              ena,
  input  logic              aclr,
  input  logic [DATA_W-1:0] radical,
  output logic [ROOT_W-1:0] root,
  output logic [REM_W-1:0]  remainder
);

  localparam int PAD_W = 2 * ROOT_W;
  localparam int PAY_W = PAD_W + ROOT_W + REM_W;
  localparam int INNER = isqrt_pkg::inner_regs(ROOT_W, LATENCY);
  localparam int EXTRA = LATENCY - INNER;
  localparam int CHK_W = PAD_W + 2;

  logic [ROOT_W:0][PAY_W-1:0] node;
  logic [EXTRA:0][PAY_W-1:0]  tail;
  logic [PAY_W-1:0]           fin;
  logic [PAD_W-1:0]           fin_rad;

  assign node[0] = {PAD_W'(radical), {ROOT_W{1'b0}}, {REM_W{1'b0}}};

  for (genvar s = 0; s < ROOT_W; s++) begin : g_stage
    logic [PAY_W-1:0] comb_out;

    isqrt_stage #(.ROOT_W(ROOT_W), .STAGE(s)) u_stage (
      .pay_in (node[s]),
      .pay_out(comb_out)
    );

    if (isqrt_pkg::reg_after(s + 1, ROOT_W, INNER)) begin : g_reg
      isqrt_pipe_reg #(.WIDTH(PAY_W)) u_reg (
        .clk (clk),
        .ena (ena),
        .aclr(aclr),
        .d   (comb_out),
        .q   (node[s+1])
      );
    end else begin : g_wire
      assign node[s+1] = comb_out;
    end
  end

  assign tail[0] = node[ROOT_W];

  for (genvar e = 0; e < EXTRA; e++) begin : g_tail
    isqrt_pipe_reg #(.WIDTH(PAY_W)) u_reg (
      .clk (clk),
      .ena (ena),
      .aclr(aclr),
      .d   (tail[e]),
      .q   (tail[e+1])
    );
  end

  assign fin       = tail[EXTRA];
  assign fin_rad   = fin[PAY_W-1 -: PAD_W];
  assign root      = fin[REM_W +: ROOT_W];
  assign remainder = fin[REM_W-1:0];

  // Output-side consistency against the sample carried alongside the result
  logic [CHK_W-1:0] sq_lo, sq_hi, recon;
  assign sq_lo = CHK_W'(root) * CHK_W'(root);
  assign sq_hi = (CHK_W'(root) + CHK_W'(1)) * (CHK_W'(root) + CHK_W'(1));
  assign recon = sq_lo + CHK_W'(remainder);

  a_r2_root_not_too_big: assert property (@(posedge clk) disable iff (aclr)
    sq_lo <= CHK_W'(fin_rad));
  a_r2_root_not_too_small: assert property (@(posedge clk) disable iff (aclr)
    sq_hi > CHK_W'(fin_rad));
  a_r3_reconstruct: assert property (@(posedge clk) disable iff (aclr)
    recon == CHK_W'(fin_rad));
  a_r3_rem_bound: assert property (@(posedge clk) disable iff (aclr)
    CHK_W'(remainder) <= (CHK_W'(root) << 1));

endmodule

// File: tb/isqrt_pipe_bench.sv
module isqrt_pipe_bench;

  localparam int LAT_A = 2;
  localparam int LAT_B = 4;

  logic clk = 1'b0;
  logic ena = 1'b0;
  logic aclr = 1'b0;
  logic [8:0] rad_a = '0;
  logic [3:0] rad_b = '0;
  logic [5:0] rad_c = '0;
  logic [4:0] root_a;
  logic [5:0] rem_a;
  logic [1:0] root_b;
  logic [2:0] rem_b;
  logic [2:0] root_c;
  logic [3:0] rem_c;

  int n_chk = 0;
  int n_err = 0;
  int qa[$];
  int qb[$];

  always #5 clk = ~clk;

  isqrt_pipe #(.DATA_W(9), .LATENCY(LAT_A)) u_isqrt_pipe (
    .clk(clk), .ena(ena), .aclr(aclr), .radical(rad_a),
    .root(root_a), .remainder(rem_a));

  isqrt_pipe #(.DATA_W(4), .LATENCY(LAT_B)) u_isqrt_pipe_deep (
    .clk(clk), .ena(ena), .aclr(aclr), .radical(rad_b),
    .root(root_b), .remainder(rem_b));

  isqrt_pipe #(.DATA_W(6), .LATENCY(0)) u_isqrt_pipe_comb (
    .clk(clk), .ena(ena), .aclr(aclr), .radical(rad_c),
    .root(root_c), .remainder(rem_c));

  function automatic int ref_pack(input int v);
    int r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return (r << 16) | (v - r * r);
  endfunction

  task automatic chk(input string tag, input int got_r, input int got_m,
                     input int exp_r, input int exp_m);
    n_chk++;
    if (got_r != exp_r || got_m != exp_m) begin
      n_err++;
      $display("FAIL %s: root=%0d rem=%0d expected root=%0d rem=%0d",
               tag, got_r, got_m, exp_r, exp_m);
    end
  endtask

  task automatic chk_int(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // driver: applies one sample at the falling edge, records expectations
  task automatic drive(input int v, input bit en);
    int e;
    @(negedge clk);
    rad_a = 9'(v);
    rad_b = 4'(v);
    rad_c = 6'(v);
    ena   = en;
    if (en) begin
      qa.push_back(ref_pack(v & 511));
      qb.push_back(ref_pack(v & 15));
    end
    #1;
    e = ref_pack(v & 63);
    chk("R5 comb", int'(root_c), int'(rem_c), e >> 16, e & 16'hffff);
  endtask

  // monitor for the 9-bit, latency-2 instance
  int  cnt_a = 0;
  int  last_ra = 0, last_ma = 0;
  bit  en_sa, cl_sa;
  always begin
    int e;
    @(posedge clk);
    en_sa = ena;
    cl_sa = aclr;
    #2;
    if (cl_sa) cnt_a = 0;
    else if (en_sa) begin
      cnt_a++;
      if (cnt_a >= LAT_A) begin
        if (qa.size() == 0) chk("R4 missing item A", int'(root_a), int'(rem_a), -1, -1);
        else begin
          e = qa.pop_front();
          chk("R2 R3 R4 R8 main", int'(root_a), int'(rem_a), e >> 16, e & 16'hffff);
        end
      end
    end else begin
      chk("R6 hold main", int'(root_a), int'(rem_a), last_ra, last_ma);
    end
    last_ra = int'(root_a);
    last_ma = int'(rem_a);
  end

  // monitor for the 4-bit, latency-4 instance (surplus delay at output)
  int  cnt_b = 0;
  int  last_rb = 0, last_mb = 0;
  bit  en_sb, cl_sb;
  always begin
    int e;
    @(posedge clk);
    en_sb = ena;
    cl_sb = aclr;
    #2;
    if (cl_sb) cnt_b = 0;
    else if (en_sb) begin
      cnt_b++;
      if (cnt_b >= LAT_B) begin
        if (qb.size() == 0) chk("R9 missing item B", int'(root_b), int'(rem_b), -1, -1);
        else begin
          e = qb.pop_front();
          chk("R9 R2 R3 deep", int'(root_b), int'(rem_b), e >> 16, e & 16'hffff);
        end
      end
    end else begin
      chk("R6 hold deep", int'(root_b), int'(rem_b), last_rb, last_mb);
    end
    last_rb = int'(root_b);
    last_mb = int'(rem_b);
  end

  initial begin
    #1 aclr = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 reset main", int'(root_a), int'(rem_a), 0, 0);
    chk("R7 reset deep", int'(root_b), int'(rem_b), 0, 0);
    chk_int("R1 root width main", $bits(u_isqrt_pipe.root), 5);
    chk_int("R1 rem width main", $bits(u_isqrt_pipe.remainder), 6);
    chk_int("R1 root width comb", $bits(u_isqrt_pipe_comb.root), 3);
    chk_int("R1 rem width comb", $bits(u_isqrt_pipe_comb.remainder), 4);
    chk_int("R1 root width deep", $bits(u_isqrt_pipe_deep.root), 2);
    chk_int("R1 rem width deep", $bits(u_isqrt_pipe_deep.remainder), 3);
    @(negedge clk);
    aclr = 1'b0;

    // exhaustive sweep, enable always high (R2 R3 R4 R8)
    for (int v = 0; v < 512; v++) drive(v, 1'b1);

    // enable toggling with scattered values (R6)
    for (int i = 0; i < 300; i++) drive((i * 181 + 7) % 512, (i % 3) != 1);

    // long hold with input changing underneath (R6)
    drive(500, 1'b1);
    for (int i = 0; i < 6; i++) drive(37 + i, 1'b0);
    drive(200, 1'b1);
    drive(511, 1'b1);
    drive(0, 1'b1);

    // asynchronous clear between clock edges (R7)
    drive(300, 1'b1);
    drive(301, 1'b1);
    @(negedge clk);
    ena = 1'b0;
    #2;
    aclr = 1'b1;
    qa.delete();
    qb.delete();
    #1;
    chk("R7 async clear main", int'(root_a), int'(rem_a), 0, 0);
    chk("R7 async clear deep", int'(root_b), int'(rem_b), 0, 0);
    @(negedge clk);
    aclr = 1'b0;

    // restart after clear, then drain
    for (int v = 480; v < 512; v++) drive(v, 1'b1);
    for (int i = 0; i < LAT_B + 1; i++) drive(0, 1'b1);
    @(negedge clk);
    ena = 1'b0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule